// File: doc/BRIEF.md
# Sectioned GPIO Controller with Interrupts

A memory-mapped general-purpose I/O controller for 32 pins. The pins are grouped into four sections of eight, and each section has its own 64-byte register window. Global pin n is bit (n mod 8) of section (n div 8). Each window holds these registers:

- direction and output value;
- a synchronised input view;
- latched interrupt status and the masked view of that status;
- a mask, with separate set and clear write registers;
- a per-pin choice between edge-triggered and level-held interrupts.

The pins are sampled through a two-flop synchroniser. That synchronised value feeds both the input register and the interrupt capture logic. The controller sits on a simple synchronous register bus:

- Writes take effect at the clock edge on which `wr_en` is high.
- Reads are combinational from `addr`.

All unmasked status bits across the four sections are ORed into one interrupt line.

Top module: `sect_gpio`

## Requirements
- R1: After reset the following hold: every direction bit is 1 and `pin_oe` is all zero; the output register and `pin_out` are zero; every mask bit is 1; every pin is in edge mode; every status bit is 0; `irq` is 0.
- R2: Address decoding works as follows:
  - `addr[7:6]` selects the section and `addr[5:2]` selects the register word.
  - Word 0 is masked status, word 1 is status, word 2 is mask read / mask clear, word 3 is mask set (write only), word 4 is direction, word 5 is output, word 6 is input and word 8 is level select.
  - Bit k of a register is pin 8·section+k.
  - Reads of word 3 and of words 7 and 9 to 15 return zero, and `rd_data[31:8]` is always zero.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1). `pin_out` always carries the output register, and both registers read back as written.
- R4: Word 6 returns the pin inputs after a two-flop synchroniser. Writes to word 0 and word 6 change no state.
- R5: A pin in edge mode sets its status bit on a rising edge of its synchronised input. An input that stays high sets nothing further.
- R6: A pin in level mode sets its status bit whenever its synchronised input is high. A clear has no effect while the input is high, and the bit stays latched after the input falls until it is cleared.
- R7: Writing 1s to word 1 clears the matching status bits, and reading word 1 returns the raw status.
- R8: Writing 1s to word 3 sets mask bits and writing 1s to word 2 clears them. Word 2 reads the mask. Word 0 reads status AND NOT mask.
- R9: `irq` is the OR of all masked status bits of all four sections.
- R10: When a clear write and a new status set hit the same bit in the same cycle, the set wins and the bit stays 1.
- R11: Writing word 8 selects level mode (1) or edge mode (0) per pin, and reading word 8 returns the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data; low 8 bits are used |
| rd_data | output | 32 | Combinational read data |
| pin_in | input | 32 | Pin input values |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A status-clear write and a fresh status set can land on the same bit at the same clock edge. The bench provokes this by raising an unmasked edge-mode pin and timing a clear of that pin's status to the exact edge at which the synchronised rise is latched. It then requires the status bit and `irq` to remain set, and requires a later clear to take effect. Level-mode clears issued while the pin is high present the same conflict on every cycle. They are judged the same way: the bit stays set until the pin falls and a further clear arrives.

// File: rtl/sect_gpio.sv
module sect_gpio #(
  parameter int NSEC = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic [NSEC*8-1:0]  pin_in,
  output logic [NSEC*8-1:0]  pin_out,
  output logic [NSEC*8-1:0]  pin_oe,
  output logic               irq
);
  localparam int NP = NSEC * 8;

  logic [NP-1:0] sync1, sync2, prev;
  logic [NP-1:0] dir, outr, mask, lvl, stat;
  logic [NP-1:0] secm, wvec, wclr, setv;
  logic [1:0]    sec;
  logic [3:0]    word;
  logic [7:0]    rsel;

  assign sec  = addr[7:6];
  assign word = addr[5:2];
  assign secm = NP'(8'hFF) << (sec * 8);
  assign wvec = NP'(wr_data[7:0]) << (sec * 8);
  assign wclr = (wr_en && word == 4'd1) ? wvec : '0;
  assign setv = (sync2 & ~prev & ~lvl) | (sync2 & lvl);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir  <= '1;
      outr <= '0;
      mask <= '1;
      lvl  <= '0;
    end else if (wr_en) begin
      case (word)
        4'd2: mask <= mask & ~wvec;
        4'd3: mask <= mask | wvec;
        4'd4: dir  <= (dir  & ~secm) | wvec;
        4'd5: outr <= (outr & ~secm) | wvec;
        4'd8: lvl  <= (lvl  & ~secm) | wvec;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~wclr) | setv;

  always_comb begin
    case (word)
      4'd0:    rsel = stat[sec*8 +: 8] & ~mask[sec*8 +: 8];
      4'd1:    rsel = stat[sec*8 +: 8];
      4'd2:    rsel = mask[sec*8 +: 8];
      4'd4:    rsel = dir[sec*8 +: 8];
      4'd5:    rsel = outr[sec*8 +: 8];
      4'd6:    rsel = sync2[sec*8 +: 8];
      4'd8:    rsel = lvl[sec*8 +: 8];
      default: rsel = 8'h00;
    endcase
  end

  assign rd_data = DW'(rsel);
  assign pin_out = outr;
  assign pin_oe  = ~dir;
  assign irq     = |(stat & ~mask);

  p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 4'd4) |=> (((pin_oe ^ ~$past(wvec)) & $past(secm)) == '0));

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == 4'd3) |=> ((~mask & $past(wvec)) == '0));

  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & $past(wclr & ~setv)) == '0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat & $past(setv)) == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat & $past(stat) & ~$past(wclr)) == '0));
endmodule

// File: tb/sect_gpio_bench.sv
`timescale 1ns/1ps
module sect_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] m_dir, m_out, m_mask, m_lvl, m_stat, m_pins;

  sect_gpio u_sect_gpio (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sl(logic [31:0] v, int s);
    return v[s*8 +: 8];
  endfunction

  function automatic logic [31:0] exp_read(int s, int w);
    case (w)
      0: return {24'h0, sl(m_stat & ~m_mask, s)};
      1: return {24'h0, sl(m_stat, s)};
      2: return {24'h0, sl(m_mask, s)};
      4: return {24'h0, sl(m_dir, s)};
      5: return {24'h0, sl(m_out, s)};
      6: return {24'h0, sl(m_pins, s)};
      8: return {24'h0, sl(m_lvl, s)};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string word_tag(int w);
    case (w)
      0, 2: return "R8";
      1: return "R7";
      4, 5: return "R3";
      6: return "R4";
      8: return "R11";
      default: return "R2";
    endcase
  endfunction

  task automatic model_write(int s, int w, logic [7:0] d);
    logic [31:0] v = 32'(d) << (s * 8);
    logic [31:0] m = 32'hFF << (s * 8);
    case (w)
      1: m_stat = m_stat & ~v;
      2: m_mask = m_mask & ~v;
      3: m_mask = m_mask | v;
      4: m_dir = (m_dir & ~m) | v;
      5: m_out = (m_out & ~m) | v;
      8: m_lvl = (m_lvl & ~m) | v;
      default: ;
    endcase
    m_stat = m_stat | (m_lvl & m_pins);
  endtask

  task automatic model_pins(logic [31:0] n);
    m_stat = m_stat | (n & ~m_pins & ~m_lvl) | (n & m_lvl);
    m_pins = n;
  endtask

  task automatic bus_write(int s, int w, logic [31:0] d);
    addr = 8'((s << 6) | (w << 2));
    wr_data = d;
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(string tag, int s, int w);
    addr = 8'((s << 6) | (w << 2));
    #1;
    chk(tag, rd_data, exp_read(s, w));
  endtask

  task automatic do_write(int s, int w, logic [31:0] d);
    bus_write(s, w, d);
    model_write(s, w, d[7:0]);
    settle();
  endtask

  task automatic do_pins(logic [31:0] n);
    pin_in = n;
    model_pins(n);
    settle();
  endtask

  task automatic full_check(int s);
    chk("R3 pin_oe", pin_oe, ~m_dir);
    chk("R3 pin_out", pin_out, m_out);
    chk("R9 irq", {31'h0, irq}, {31'h0, |(m_stat & ~m_mask)});
    for (int w = 0; w < 16; w++) rd_chk(word_tag(w), s, w);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_dir = '1; m_out = '0; m_mask = '1; m_lvl = '0; m_stat = '0; m_pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    for (int s = 0; s < 4; s++) begin
      rd_chk("R1 mask", s, 2);
      rd_chk("R1 dir", s, 4);
      rd_chk("R1 level", s, 8);
      rd_chk("R1 status", s, 1);
    end

    // R10: clear lands on the edge where the synchronised rise is latched
    do_write(1, 2, 32'h08);
    pin_in = 32'h0000_0800;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    bus_write(1, 1, 32'h08);
    m_stat = m_stat | 32'h0000_0800;
    m_pins = 32'h0000_0800;
    settle();
    rd_chk("R10 status kept", 1, 1);
    chk("R10 irq", {31'h0, irq}, 32'h1);
    do_write(1, 1, 32'h08);
    rd_chk("R7 cleared, R5 no new edge", 1, 1);
    chk("R9 irq low", {31'h0, irq}, 32'h0);

    // R6: level mode clear while high, latch after fall
    do_write(2, 8, 32'h01);
    do_pins(32'h0001_0800);
    do_write(2, 1, 32'h01);
    rd_chk("R6 clear while high", 2, 1);
    do_pins(32'h0000_0800);
    rd_chk("R6 latched after fall", 2, 1);
    do_write(2, 1, 32'h01);
    rd_chk("R6 cleared when low", 2, 1);

    // R4: writes to read-only words ignored
    do_write(3, 6, 32'hFF);
    do_write(3, 0, 32'hFF);
    full_check(3);

    for (int i = 0; i < 300; i++) begin
      if ($urandom % 2) do_pins($urandom);
      else do_write(int'($urandom % 4), int'($urandom % 16), $urandom);
      full_check(int'($urandom % 4));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule